// File: doc/BRIEF.md
# Fixed Off-Time Chopping Current Regulator

This block is the digital half of a current chopper for one H-bridge winding. It starts each cycle by driving the bridge so that winding current rises in the commanded polarity. A synchronized comparator flag reports when the sensed current has reached the target. Once that flag is accepted, the block leaves the drive state and starts an off interval. The off interval lasts for a programmed number of clock cycles and does not depend on how the current behaves.

During the off interval the winding recirculates in one of three ways. In slow decay, only the high side is released. In fast decay, both sides are released and the current reverses through the bridge. In mixed decay, the interval begins with a programmed fast segment and finishes in slow decay. At every drive start the block ignores the comparator for a programmed blanking count, so switching transients cannot end a drive phase early.

The block also has a priority path. A fault or a deasserted enable turns every switch off. A zero target amplitude parks the bridge in slow decay and keeps it out of the drive state.

Top module: `chop_current_ctrl`

## Requirements
- R1: While `rst` is high, `bridge_cmd` is 2'b00 (all off). The four bridge codes are 00 = all off, 01 = drive, 10 = slow decay and 11 = fast decay.
- R2: When the block is enabled, fault-free and has a nonzero target, and it sits in the all-off state, `bridge_cmd` becomes 01 (drive) on the next clock.
- R3: In each drive phase, `sense_trip` is ignored for the first `blank_len` cycles. The count is taken at the clock edge that enters the drive state.
- R4: Once blanking has expired, a high `sense_trip` moves the bridge out of drive on the next clock. While `sense_trip` stays low, the bridge stays in drive.
- R5: When `decay_mode` is 2'b00 (slow), the whole off interval is spent in code 10.
- R6: When `decay_mode` is 2'b01 (fast), the whole off interval is spent in code 11.
- R7: When `decay_mode` is 2'b10 or 2'b11 (mixed), the off interval spends its first `fast_len` cycles in code 11 and the rest in code 10.
- R8: In mixed decay, a `fast_len` at or above `off_len` gives an interval that is entirely fast. A `fast_len` of 0 gives an interval that is entirely slow.
- R9: The off interval lasts exactly `off_len` cycles, with a value of 0 treated as 1. When it ends, a new drive phase starts with blanking applied, whatever the value of `sense_trip`.
- R10: A low `bridge_en` or a high `fault` forces code 00 on the next clock and holds it. Once both are cleared, a new drive phase starts.
- R11: While `zero_amp` is high and the block is enabled and fault-free, the code is 10 and drive never appears. When `zero_amp` is released, the next clock starts a drive phase.
- R12: `decay_mode`, `off_len` and `fast_len` are sampled at the edge that enters the off interval. Changing them inside the interval has no effect on that interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bridge_en | input | 1 | Output enable; low forces all switches off |
| fault | input | 1 | Over-temperature or gate-supply fault; high forces all switches off |
| sense_trip | input | 1 | Synchronized comparator flag: sensed current at or above target |
| zero_amp | input | 1 | Target amplitude is zero; hold slow decay |
| decay_mode | input | 2 | 00 slow, 01 fast, 10/11 mixed |
| off_len | input | CNT_W | Off-interval length in cycles |
| blank_len | input | CNT_W | Comparator blanking length in cycles |
| fast_len | input | CNT_W | Fast segment length in mixed decay |
| bridge_cmd | output | 2 | Bridge state command |

## Verification
A behavioural reference model counts the elapsed cycles of each phase and is compared with the design on every clock.

The comparator flag is driven in three ways:
- Held high: each chopping cycle is then timed only by the blanking and off counts, so a wrong interval length stands out.
- Held low: the drive phase must persist.
- A pseudo-random pattern: trips land both inside and outside the blanking window.

Each decay mode is run, and mixed decay is tried with fast segments shorter than, equal to, longer than and zero against the off length. Further sections do the following:
- toggle `decay_mode` and the lengths inside an interval;
- pulse `fault` and `bridge_en`;
- raise `zero_amp` during drive and during decay.

Together these separate the priority order from the timing logic.

// File: rtl/chop_pkg.sv
package chop_pkg;

    // Bridge state command; codes are visible at the top-level port.
    typedef enum logic [1:0] {
        BR_OFF   = 2'b00,
        BR_DRIVE = 2'b01,
        BR_SLOW  = 2'b10,
        BR_FAST  = 2'b11
    } bridge_e;

    // Requested recirculation style.
    typedef enum logic [1:0] {
        DK_SLOW   = 2'b00,
        DK_FAST   = 2'b01,
        DK_MIXED  = 2'b10,
        DK_MIXED2 = 2'b11
    } decay_e;

    // Timer bank layout.
    localparam int NUM_TMR   = 3;
    localparam int TMR_OFF   = 0;
    localparam int TMR_BLANK = 1;
    localparam int TMR_SEG   = 2;

    // First recirculation state of an off interval.
    function automatic bridge_e off_entry_state(decay_e mode, logic seg_empty);
        case (mode)
            DK_SLOW: return BR_SLOW;
            DK_FAST: return BR_FAST;
            default: return seg_empty ? BR_SLOW : BR_FAST;
        endcase
    endfunction

    // Mixed decay is the only mode that uses the fast segment timer.
    function automatic logic uses_segment(decay_e mode);
        return mode[1];
    endfunction

endpackage

// File: rtl/chop_down_timer.sv
module chop_down_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt
);

    // Loadable counter that runs down to zero and stops there.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/chop_phase_fsm.sv
module chop_phase_fsm
    import chop_pkg::*;
#(
    parameter int W = 10
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        en,
    input  logic                        fault,
    input  logic                        trip,
    input  logic                        zero_amp,
    input  logic [1:0]                  decay_mode,
    input  logic [W-1:0]                off_len,
    input  logic [W-1:0]                blank_len,
    input  logic [W-1:0]                fast_len,
    input  logic [NUM_TMR-1:0][W-1:0]   tmr_cnt,
    output logic [NUM_TMR-1:0]          tmr_load,
    output logic [NUM_TMR-1:0][W-1:0]   tmr_val,
    output bridge_e                     state
);

    localparam logic [W-1:0] CNT_ONE = W'(1);

    bridge_e state_nx;
    decay_e  mode;
    logic    off_done;
    logic    seg_done;
    logic    blank_open;

    assign mode       = decay_e'(decay_mode);
    assign off_done   = (tmr_cnt[TMR_OFF] <= CNT_ONE);
    assign seg_done   = (tmr_cnt[TMR_SEG] == CNT_ONE);
    assign blank_open = (tmr_cnt[TMR_BLANK] == '0);

    always_comb begin
        state_nx = state;
        tmr_load = '0;
        tmr_val  = '0;

        if (!en || fault) begin
            // Safety path: every switch off, all timing discarded.
            state_nx = BR_OFF;
            tmr_load = '1;
        end else if (zero_amp) begin
            // No target: park in slow decay; an expired off timer releases it later.
            state_nx = BR_SLOW;
            tmr_load = '1;
        end else begin
            case (state)
                BR_OFF: begin
                    state_nx            = BR_DRIVE;
                    tmr_load[TMR_BLANK] = 1'b1;
                    tmr_val[TMR_BLANK]  = blank_len;
                end
                BR_DRIVE: begin
                    if (blank_open && trip) begin
                        state_nx          = off_entry_state(mode, fast_len == '0);
                        tmr_load[TMR_OFF] = 1'b1;
                        tmr_val[TMR_OFF]  = off_len;
                        tmr_load[TMR_SEG] = 1'b1;
                        tmr_val[TMR_SEG]  = uses_segment(mode) ? fast_len : '0;
                    end
                end
                BR_SLOW, BR_FAST: begin
                    if (off_done) begin
                        state_nx            = BR_DRIVE;
                        tmr_load[TMR_BLANK] = 1'b1;
                        tmr_val[TMR_BLANK]  = blank_len;
                    end else if (state == BR_FAST && seg_done) begin
                        state_nx = BR_SLOW;
                    end
                end
                default: state_nx = BR_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= BR_OFF;
        end else begin
            state <= state_nx;
        end
    end

endmodule

// File: rtl/chop_current_ctrl.sv
module chop_current_ctrl
    import chop_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bridge_en,
    input  logic             fault,
    input  logic             sense_trip,
    input  logic             zero_amp,
    input  logic [1:0]       decay_mode,
    input  logic [CNT_W-1:0] off_len,
    input  logic [CNT_W-1:0] blank_len,
    input  logic [CNT_W-1:0] fast_len,
    output logic [1:0]       bridge_cmd
);

    logic [NUM_TMR-1:0]            tmr_load;
    logic [NUM_TMR-1:0][CNT_W-1:0] tmr_val;
    logic [NUM_TMR-1:0][CNT_W-1:0] tmr_cnt;
    bridge_e                       state;

    chop_phase_fsm #(.W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .en         (bridge_en),
        .fault      (fault),
        .trip       (sense_trip),
        .zero_amp   (zero_amp),
        .decay_mode (decay_mode),
        .off_len    (off_len),
        .blank_len  (blank_len),
        .fast_len   (fast_len),
        .tmr_cnt    (tmr_cnt),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .state      (state)
    );

    // Off-interval, blanking and fast-segment timers share one structure.
    for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
        chop_down_timer #(.W(CNT_W)) u_tmr (
            .clk      (clk),
            .rst      (rst),
            .load     (tmr_load[gi]),
            .load_val (tmr_val[gi]),
            .cnt      (tmr_cnt[gi])
        );
    end

    assign bridge_cmd = state;

endmodule

// File: rtl/chop_current_ctrl_chk.sv
module chop_current_ctrl_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             bridge_en,
    input logic             fault,
    input logic             sense_trip,
    input logic             zero_amp,
    input logic [CNT_W-1:0] off_len,
    input logic [CNT_W-1:0] blank_len,
    input logic [1:0]       bridge_cmd
);

    logic active;
    assign active = bridge_en && !fault && !zero_amp;

    // R10
    fault_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!bridge_en || fault) |=> bridge_cmd == 2'b00);

    // R11
    zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bridge_en && !fault && zero_amp) |=> bridge_cmd == 2'b10);

    // R4
    drive_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bridge_cmd == 2'b01 && active && !sense_trip) |=> bridge_cmd == 2'b01);

    // R3
    blank_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (bridge_cmd == 2'b01 && $past(bridge_cmd) != 2'b01 &&
         $past(blank_len) != '0 && active) |=> bridge_cmd == 2'b01);

    // R9
    off_span_chk: assert property (@(posedge clk) disable iff (rst)
        (bridge_cmd[1] && $past(bridge_cmd) == 2'b01 &&
         $past(off_len) >= CNT_W'(2) && active) |=> bridge_cmd[1]);

    // R7
    no_slow_to_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (bridge_cmd == 2'b10) |=> bridge_cmd != 2'b11);

endmodule

bind chop_current_ctrl chop_current_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bridge_en  (bridge_en),
    .fault      (fault),
    .sense_trip (sense_trip),
    .zero_amp   (zero_amp),
    .off_len    (off_len),
    .blank_len  (blank_len),
    .bridge_cmd (bridge_cmd)
);

// File: tb/tb_chop_current_ctrl.sv
`timescale 1ns/1ps
module tb_chop_current_ctrl;

    localparam int CNT_W = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bridge_en = 1'b0;
    logic             fault = 1'b0;
    logic             sense_trip = 1'b0;
    logic             zero_amp = 1'b0;
    logic [1:0]       decay_mode = 2'b00;
    logic [CNT_W-1:0] off_len = '0;
    logic [CNT_W-1:0] blank_len = '0;
    logic [CNT_W-1:0] fast_len = '0;
    logic [1:0]       bridge_cmd;

    chop_current_ctrl #(.CNT_W(CNT_W)) dut (
        .clk        (clk),
        .rst        (rst),
        .bridge_en  (bridge_en),
        .fault      (fault),
        .sense_trip (sense_trip),
        .zero_amp   (zero_amp),
        .decay_mode (decay_mode),
        .off_len    (off_len),
        .blank_len  (blank_len),
        .fast_len   (fast_len),
        .bridge_cmd (bridge_cmd)
    );

    always #2.5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Reference model: phase plus elapsed-cycle bookkeeping.
    int m_st = 0;      // 0 off, 1 drive, 2 slow, 3 fast
    int m_el = 0;
    int m_off_n = 1;
    int m_fast_n = 0;
    int m_blank_n = 0;
    bit m_mixed = 0;
    bit m_hold = 0;

    task automatic m_start_drive();
        m_st = 1;
        m_el = 0;
        m_blank_n = int'(blank_len);
        m_hold = 0;
    endtask

    always @(posedge clk) begin
        if (rst || !bridge_en || fault) begin
            m_st = 0;
            m_hold = 0;
        end else if (zero_amp) begin
            m_st = 2;
            m_hold = 1;
        end else if (m_st == 0) begin
            m_start_drive();
        end else if (m_st == 1) begin
            if (m_el >= m_blank_n && sense_trip) begin
                m_off_n = (off_len == 0) ? 1 : int'(off_len);
                m_el = 0;
                m_mixed = 0;
                if (decay_mode == 2'b00) m_st = 2;
                else if (decay_mode == 2'b01) m_st = 3;
                else if (fast_len == 0) m_st = 2;
                else begin
                    m_st = 3;
                    m_mixed = 1;
                    m_fast_n = int'(fast_len);
                end
            end else begin
                m_el++;
            end
        end else if (m_hold) begin
            m_start_drive();
        end else begin
            m_el++;
            if (m_el >= m_off_n) m_start_drive();
            else if (m_st == 3 && m_mixed && m_el >= m_fast_n) m_st = 2;
        end
    end

    // Compare on every falling edge, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (int'(bridge_cmd) != m_st) begin
                errors++;
                $display("FAIL %s t=%0t bridge_cmd actual=%0d expected=%0d",
                         cur_req, $time, bridge_cmd, m_st);
            end
        end
    end

    logic [15:0] lfsr = 16'hACE1;

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_random(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sense_trip = lfsr[0] & lfsr[3];
        end
    endtask

    task automatic set_lens(int off_v, int blank_v, int fast_v);
        off_len   = CNT_W'(off_v);
        blank_len = CNT_W'(blank_v);
        fast_len  = CNT_W'(fast_v);
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        run(3);
        @(negedge clk);
        rst = 1'b0;

        // R2, R3, R5, R9: slow decay with the comparator stuck high
        cur_req = "R2";
        set_lens(6, 4, 0);
        decay_mode = 2'b00;
        sense_trip = 1'b1;
        bridge_en = 1'b1;
        run(4);
        cur_req = "R5";
        run(40);

        // R4: comparator low keeps drive, then trip
        cur_req = "R4";
        sense_trip = 1'b0;
        run(20);
        sense_trip = 1'b1;
        run(10);

        // R6: fast decay
        cur_req = "R6";
        decay_mode = 2'b01;
        run(40);

        // R7: mixed, short fast segment, both mixed codes
        cur_req = "R7";
        decay_mode = 2'b10;
        set_lens(7, 2, 3);
        run(40);
        decay_mode = 2'b11;
        set_lens(7, 2, 1);
        run(30);

        // R8: fast segment at or over the interval, and zero
        cur_req = "R8";
        set_lens(5, 2, 5);
        run(25);
        set_lens(5, 2, 9);
        run(25);
        set_lens(5, 2, 0);
        run(25);

        // R9: zero off length, zero blanking
        cur_req = "R9";
        decay_mode = 2'b00;
        set_lens(0, 0, 0);
        run(20);
        set_lens(1, 0, 0);
        run(20);

        // R3: random comparator against a wide blanking window
        cur_req = "R3";
        decay_mode = 2'b10;
        set_lens(9, 5, 4);
        run_random(200);

        // R12: settings changed inside intervals
        cur_req = "R12";
        sense_trip = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            decay_mode = 2'(i % 4);
            set_lens(3 + (i % 5), 1 + (i % 3), i % 6);
        end

        // R10: fault and enable
        cur_req = "R10";
        set_lens(8, 3, 3);
        run(7);
        fault = 1'b1;
        run(5);
        fault = 1'b0;
        run(12);
        bridge_en = 1'b0;
        run(4);
        bridge_en = 1'b1;
        run(15);
        fault = 1'b1;
        zero_amp = 1'b1;
        run(3);
        fault = 1'b0;
        run(3);
        zero_amp = 1'b0;
        run(6);

        // R11: zero target during drive and during decay
        cur_req = "R11";
        sense_trip = 1'b0;
        run(3);
        zero_amp = 1'b1;
        run(10);
        zero_amp = 1'b0;
        run(4);
        sense_trip = 1'b1;
        run(5);
        zero_amp = 1'b1;
        run(3);
        zero_amp = 1'b0;
        run_random(100);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule